// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Update-Event Control

This block is a general-purpose up-counting timer. A prescaler divides the timer clock by a programmable ratio and each prescaled tick advances a counter from zero up to an active reload limit, after which it wraps back to zero. The wrap is an overflow and is the normal source of an update event. On an update event, the timer copies its buffered prescale value, and optionally its buffered reload value, into the active copies. It also sets an update flag that can drive an interrupt request.

Software reaches the timer through a simple single-cycle register port. It can gate or filter update events, stop the counter automatically after one period, choose immediate or buffered reload writes, and read the update flag in the top bit of the counter readback. A free-running strobe at 1, 1/2 or 1/4 of the timer clock rate is provided for downstream sampling logic.

Register addresses on `regAddr`: 0 control, 1 interrupt enable (bit 0), 2 status (bit 0 is the update flag), 3 update-generate (writing bit 0 as 1 issues a software update request), 4 counter readback (read only), 5 prescale buffer, 6 reload buffer. Writes take effect at the clock edge where `regWr` is high; `regRdData` shows the addressed register's current value without delay.

Top module: `tick_timer`

## Requirements
- R1: After reset the control register, the interrupt enable, the update flag, the counter and the interrupt request are all zero, and the active prescale and reload values are zero.
- R2: The counter changes only while control bit 0 (run) is 1 or when a software update request is issued; with run at 0 the counter holds its value.
- R3: With run at 1, the counter advances by one every (active prescale + 1) timer clocks, counts from 0 to the active reload value, and on the next tick wraps to 0; that wrap is an overflow.
- R4: While control bit 1 (update block) is 1, no update event is produced: the update flag is not set and the active prescale and reload values are not changed, even on overflow.
- R5: A software update request always clears the counter and the prescaler phase at the next edge, including while update block is 1.
- R6: Control bit 2 (overflow-only) selects the update source: at 0 both overflow and a software request produce an update event; at 1 only overflow does.
- R7: With control bit 3 (single-shot) at 1, an update event clears control bit 0 in hardware, so the counter stops at 0 after its period.
- R8: With control bit 7 (buffered reload) at 0, a write to the reload register sets the active reload value at once; at 1 the write goes to the buffer and reaches the active value only on an update event.
- R9: A write to the prescale register always goes to the buffer and reaches the active prescale value only on an update event.
- R10: Control bits 9:8 set the period of `sampleEn`: 0 gives a pulse every clock, 1 every 2 clocks, 2 every 4 clocks; the reserved value 3 behaves as 0.
- R11: With control bit 11 (flag mirror) at 1, bit 31 of the counter readback equals the update flag; with it at 0, bit 31 reads 0.
- R12: The update flag (status bit 0) is set by every update event and cleared by writing 0 to status bit 0; `irq` is high exactly when the flag and interrupt-enable bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the addressed register |
| irq | output | 1 | Update interrupt request |
| sampleEn | output | 1 | Divided sampling-clock enable |

## Verification
Every register write lands on the edge where the strobe is high, so control, flag, interrupt and counter values are due one edge after the write, and the bench reads them one nanosecond after that edge. The counter result after enabling is computed as the number of prescaled ticks in the edges that follow the enabling write, modulo the reload value plus one, and the bench waits an exact number of edges before reading. Buffered prescale and reload values are checked through counting rate, sampled only after the update event's edge has passed, and the sampling strobe is counted over eight consecutive clocks so any phase gives the same total.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_UGEN = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PSC  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ARR  = 3'd6;

  // Control bit positions
  localparam int B_RUN   = 0;
  localparam int B_UBLK  = 1;
  localparam int B_OVONL = 2;
  localparam int B_SSHOT = 3;
  localparam int B_BUFRL = 7;
  localparam int B_DIVLO = 8;
  localparam int B_MIRR  = 11;
  localparam logic [11:0] CTRL_MASK = 12'hB8F;

  // Strobes from control to datapath
  typedef struct packed {
    logic reinit;   // software request: clear counter and prescaler phase
    logic loadPsc;  // update event: copy prescale buffer
    logic loadArr;  // update event with buffered reload
    logic arrNow;   // direct reload write
  } dp_strobe_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic              ovf,
  input  logic [CNT_W-1:0]  cntVal,
  output dp_strobe_t        stb,
  output logic [11:0]       ctrlQ,
  output logic              flagQ,
  output logic              irq,
  output logic [PSC_W-1:0]  pscBufQ,
  output logic [CNT_W-1:0]  arrBufQ,
  output logic [31:0]       regRdData
);

  logic ienQ;
  logic wrCtrl, wrIen, wrStat, wrPsc, wrArr;
  logic ugStrobe, updEvt;

  assign wrCtrl   = regWr && (regAddr == A_CTRL);
  assign wrIen    = regWr && (regAddr == A_IEN);
  assign wrStat   = regWr && (regAddr == A_STAT);
  assign wrPsc    = regWr && (regAddr == A_PSC);
  assign wrArr    = regWr && (regAddr == A_ARR);
  assign ugStrobe = regWr && (regAddr == A_UGEN) && regWrData[0];

  assign updEvt = !ctrlQ[B_UBLK] && (ovf || (ugStrobe && !ctrlQ[B_OVONL]));

  always_comb begin
    stb.reinit  = ugStrobe;
    stb.loadPsc = updEvt;
    stb.loadArr = updEvt && ctrlQ[B_BUFRL];
    stb.arrNow  = wrArr && !ctrlQ[B_BUFRL];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      ienQ    <= 1'b0;
      flagQ   <= 1'b0;
      pscBufQ <= '0;
      arrBufQ <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= regWrData[11:0] & CTRL_MASK;
      // single-shot stop takes priority over a software write
      if (updEvt && ctrlQ[B_SSHOT]) ctrlQ[B_RUN] <= 1'b0;
      if (wrIen) ienQ <= regWrData[0];
      if (wrStat && !regWrData[0]) flagQ <= 1'b0;
      if (updEvt) flagQ <= 1'b1;
      if (wrPsc) pscBufQ <= regWrData[PSC_W-1:0];
      if (wrArr) arrBufQ <= regWrData[CNT_W-1:0];
    end
  end

  assign irq = flagQ && ienQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL: regRdData = 32'(ctrlQ);
      A_IEN:  regRdData = 32'(ienQ);
      A_STAT: regRdData = 32'(flagQ);
      A_CNT: begin
        regRdData     = 32'(cntVal);
        regRdData[31] = ctrlQ[B_MIRR] && flagQ;
      end
      A_PSC:  regRdData = 32'(pscBufQ);
      A_ARR:  regRdData = 32'(arrBufQ);
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [1:0]       divSel,
  input  dp_strobe_t       stb,
  input  logic [PSC_W-1:0] pscBuf,
  input  logic [CNT_W-1:0] arrBuf,
  input  logic [CNT_W-1:0] arrWrVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovf,
  output logic             sampleEn
);

  logic [PSC_W-1:0] pscCnt, pscAct;
  logic [CNT_W-1:0] arrAct;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic             tick;

  assign tick = run && (pscCnt >= pscAct);
  assign ovf  = tick && (cntVal == arrAct);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscCnt <= '0;
      cntVal <= '0;
    end else if (stb.reinit) begin
      pscCnt <= '0;
      cntVal <= '0;
    end else if (run) begin
      if (tick) begin
        pscCnt <= '0;
        cntVal <= ovf ? '0 : cntVal + 1'b1;
      end else begin
        pscCnt <= pscCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscAct <= '0;
      arrAct <= '0;
    end else begin
      if (stb.loadPsc) pscAct <= pscBuf;
      if (stb.arrNow) arrAct <= arrWrVal;
      else if (stb.loadArr) arrAct <= arrBuf;
    end
  end

  always_comb begin
    case (divSel)
      2'd1:    divMask = DIV_W'(1);
      2'd2:    divMask = DIV_W'(3);
      default: divMask = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 1'b1;
  end

  assign sampleEn = ((divCnt & divMask) == '0);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        irq,
  output logic        sampleEn
);

  dp_strobe_t       stb;
  logic [11:0]      ctrlQ;
  logic             flagQ;
  logic [PSC_W-1:0] pscBufQ;
  logic [CNT_W-1:0] arrBufQ;
  logic [CNT_W-1:0] cntVal;
  logic             ovf;

  tick_timer_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .ovf(ovf), .cntVal(cntVal), .stb(stb),
    .ctrlQ(ctrlQ), .flagQ(flagQ), .irq(irq), .pscBufQ(pscBufQ),
    .arrBufQ(arrBufQ), .regRdData(regRdData)
  );

  tick_timer_dp #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_dp (
    .clk(clk), .rstN(rstN), .run(ctrlQ[B_RUN]),
    .divSel(ctrlQ[B_DIVLO+1:B_DIVLO]), .stb(stb), .pscBuf(pscBufQ),
    .arrBuf(arrBufQ), .arrWrVal(regWrData[CNT_W-1:0]),
    .cntVal(cntVal), .ovf(ovf), .sampleEn(sampleEn)
  );

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [11:0]      ctrlQ,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             updEvt,
  input logic             ugStrobe
);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[0] && !ugStrobe) |=> $stable(cnt));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> (cnt == '0));

  assert_blocked_no_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[1] |=> !$rose(flag));

  assert_request_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    ugStrobe |=> (cnt == '0));

  assert_single_shot_stop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (updEvt && ctrlQ[3]) |=> !ctrlQ[0]);

  assert_flag_from_event_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(updEvt));

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlQ(ctrlQ), .flag(flagQ), .cnt(cntVal),
  .ovf(ovf), .updEvt(stb.loadPsc), .ugStrobe(stb.reinit)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;
  logic        sampleEn;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tick_timer uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .sampleEn(sampleEn)
  );

  typedef struct packed {
    logic [15:0] psc;
    logic [15:0] arr;
    logic [15:0] wt;
    logic [15:0] exp;
  } vec_t;

  // counter = floor(wait/(psc+1)) mod (arr+1)
  localparam vec_t VEC [5] = '{
    '{16'd0, 16'd9, 16'd5,  16'd5},
    '{16'd0, 16'd3, 16'd6,  16'd2},
    '{16'd2, 16'd9, 16'd10, 16'd3},
    '{16'd1, 16'd4, 16'd13, 16'd1},
    '{16'd3, 16'd2, 16'd20, 16'd2}
  };

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(posedge clk); #1;
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic countSample(output int n);
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (sampleEn) n++;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd2, v); chk("R1 flag", v, 0);
    rd(3'd4, v); chk("R1 counter", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R3 vector table, direct reload (R8 immediate path)
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, 32'h0);
      wr(3'd5, 32'(VEC[i].psc));
      wr(3'd6, 32'(VEC[i].arr));
      wr(3'd3, 32'h1);
      wr(3'd2, 32'h0);
      wr(3'd0, 32'h1);
      waitClk(int'(VEC[i].wt));
      rd(3'd4, v); chk("R3 count", v, 32'(VEC[i].exp));
    end

    // R2 stopped counter holds
    wr(3'd0, 32'h0);
    rd(3'd4, v);
    waitClk(5);
    begin
      logic [31:0] v2;
      rd(3'd4, v2); chk("R2 hold", v2, v);
    end

    // baseline: psc 0, arr 9
    wr(3'd5, 32'h0); wr(3'd6, 32'd9); wr(3'd3, 32'h1); wr(3'd2, 32'h0);

    // R4/R9 update block: prescale write not loaded by request
    wr(3'd0, 32'h2);
    wr(3'd5, 32'd3);
    wr(3'd3, 32'h1);
    rd(3'd2, v); chk("R4 no flag on request", v, 0);
    wr(3'd0, 32'h3);
    waitClk(4);
    rd(3'd4, v); chk("R9 prescale not loaded", v, 4);
    waitClk(6);
    rd(3'd4, v); chk("R3 wrap while blocked", v, 0);
    rd(3'd2, v); chk("R4 no flag on overflow", v, 0);
    waitClk(3);
    // R5 request clears while blocked
    wr(3'd3, 32'h1);
    rd(3'd4, v); chk("R5 request clears", v, 0);
    wr(3'd0, 32'h0);

    // R6 overflow-only source
    wr(3'd0, 32'h4);
    wr(3'd3, 32'h1);
    rd(3'd2, v); chk("R6 request ignored", v, 0);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h1);
    rd(3'd2, v); chk("R6 request makes event", v, 1);
    // R9 prescale 3 now active
    wr(3'd2, 32'h0);
    wr(3'd0, 32'h1);
    waitClk(8);
    rd(3'd4, v); chk("R9 prescale loaded", v, 2);
    wr(3'd0, 32'h0);
    wr(3'd5, 32'h0); wr(3'd3, 32'h1); wr(3'd2, 32'h0);

    // R7 single shot
    wr(3'd6, 32'd3); wr(3'd3, 32'h1); wr(3'd2, 32'h0);
    wr(3'd0, 32'h9);
    waitClk(6);
    rd(3'd0, v); chk("R7 run cleared", v, 32'h8);
    rd(3'd4, v); chk("R7 counter at zero", v, 0);
    rd(3'd2, v); chk("R12 flag on overflow", v, 1);

    // R12 interrupt and clear
    chk("R12 irq masked", 32'(irq), 0);
    wr(3'd1, 32'h1);
    chk("R12 irq raised", 32'(irq), 1);
    wr(3'd2, 32'h0);
    chk("R12 irq cleared", 32'(irq), 0);
    rd(3'd2, v); chk("R12 flag cleared", v, 0);
    wr(3'd1, 32'h0);

    // R11 flag mirror
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h1);
    wr(3'd0, 32'h800);
    rd(3'd4, v); chk("R11 mirror on", v, 32'h8000_0000);
    wr(3'd0, 32'h0);
    rd(3'd4, v); chk("R11 mirror off", v, 0);
    wr(3'd2, 32'h0);

    // R8 buffered reload
    wr(3'd6, 32'd9); wr(3'd3, 32'h1); wr(3'd2, 32'h0);
    wr(3'd0, 32'h81);
    wr(3'd6, 32'd2);
    waitClk(4);
    rd(3'd4, v); chk("R8 buffer not active", v, 5);
    waitClk(5);
    rd(3'd4, v); chk("R8 wrap at old limit", v, 0);
    waitClk(4);
    rd(3'd4, v); chk("R8 new limit active", v, 1);
    wr(3'd0, 32'h0);

    // R10 sampling strobe ratio
    countSample(n); chk("R10 ratio 1", 32'(n), 8);
    wr(3'd0, 32'h100); countSample(n); chk("R10 ratio 2", 32'(n), 4);
    wr(3'd0, 32'h200); countSample(n); chk("R10 ratio 4", 32'(n), 2);
    wr(3'd0, 32'h300); countSample(n); chk("R10 reserved", 32'(n), 8);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule